// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the register-mapped controller for a multi-channel successive-approximation analog-to-digital converter in a small microcontroller. Software selects a conversion clock, picks an analog channel and the pins given over to analog use, and then launches a conversion with a start pulse: the start bit is written to 1 and then back to 0. The block drives the channel select and a 10-bit trial code to an external DAC and comparator. It reads back the comparator decision, builds the result one bit at a time from the MSB down, and reports completion through an active-low done flag and an optional one-cycle interrupt pulse.

Changing the channel leaves the converter disarmed. The first start pulse after such a change only re-arms it and sets the flag. A second pulse is needed to run a conversion. A start pulse issued while a conversion is running abandons that conversion and begins again from the sample step.

Register map (byte-wide, `bus_addr`):
- 0, control: bit 7 start, bit 6 done flag (active low, read-only), bits 5:3 channel, bits 2:0 analog pin enables.
- 1, clock select: bits 6:5.
- 2, result high: result bits 9:2.
- 3, result low: result bits 1:0 in bits 7:6, with the other bits reading 0.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, the control register reads 8'h40 (flag 1, every other field 0), the clock select and both result registers read 0, and `irq`, `sample_en` and `trial_code` are 0.
- R2: A control write that takes the start bit from 0 to 1 does not start a conversion. `sample_en` stays 0 and `trial_code` is unchanged until the start bit is written back to 0.
- R3: When the converter is armed, a control write that takes the start bit from 1 to 0 starts a conversion. The flag reads 1 on the next cycle, and `sample_en` is high during the sample step.
- R4: The conversion has one sample step and then 10 trials, MSB first. A trial keeps its bit when `cmp_ge` is 1, meaning the input is at or above `trial_code`. With an ideal comparator the result equals the input code, including codes 0 and 1023.
- R5: The result high and low registers both update in the cycle the flag falls. They hold their value through any later conversion until that conversion completes.
- R6: Clock select 0 gives an ADC tick every 2 system clocks, select 1 every 8, and selects 2 and 3 every 32. The flag falls exactly 11 ticks after the edge on which the starting write is taken.
- R7: A control write that changes the channel field aborts any conversion, clears the flag to 0 and disarms the converter. The next start pulse only sets the flag to 1 and arms, with no conversion. A write that changes only the pin enables does not disarm.
- R8: `irq` is high for exactly one cycle, in the cycle the flag falls, and only when both `irq_global_en` and `irq_adc_en` are 1. With either enable at 0 the flag still falls.
- R9: A start pulse during a conversion restarts it from the sample step. The flag then falls 11 ticks after the restarting write.
- R10: `chan_sel` and `pin_ana_en` follow the channel and pin fields of the control register, and a single write updates both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| irq_global_en | input | 1 | Global interrupt enable |
| irq_adc_en | input | 1 | Converter interrupt enable |
| cmp_ge | input | 1 | Comparator: input at or above the DAC level |
| chan_sel | output | 3 | Analog channel routed to the converter |
| pin_ana_en | output | 3 | Pins switched to analog use |
| trial_code | output | 10 | Code driven to the DAC |
| sample_en | output | 1 | High during the sample step |
| irq | output | 1 | End-of-conversion interrupt pulse |

## Verification
The hardest state to reach is a disarmed converter that receives a pulse which must only arm it. A channel change mid-stream, followed by a lone pulse, has to be seen to produce no sample step, no moving trial code and a flag that stays high over several tick periods. The stimulus reaches this by tracking the current channel in the bench: every random iteration that draws a new channel first issues an arming pulse and checks it before converting. Directed cases add an abort in the middle of a conversion, pin-only writes, and the extreme input codes.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int DIV_A = 2,
  parameter int DIV_B = 8,
  parameter int DIV_C = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       irq_global_en,
  input  logic       irq_adc_en,
  input  logic       cmp_ge,
  output logic [2:0] chan_sel,
  output logic [2:0] pin_ana_en,
  output logic [9:0] trial_code,
  output logic       sample_en,
  output logic       irq
);
  localparam int CW = $clog2(DIV_C);

  typedef enum logic [1:0] {S_IDLE, S_SAMP, S_TRIAL} st_t;

  st_t           st;
  logic          go_q, done_n, armed;
  logic [2:0]    chan_q, pins_q;
  logic [1:0]    clk_sel;
  logic [CW-1:0] div_cnt, div_lim;
  logic [9:0]    sar, mask, res;

  wire ctrl_wr  = bus_wr && bus_addr == 2'd0;
  wire chan_chg = ctrl_wr && bus_wdata[5:3] != chan_q;
  wire go_fall  = ctrl_wr && go_q && !bus_wdata[7];
  wire tick     = div_cnt == div_lim;

  always_comb
    case (clk_sel)
      2'd0:    div_lim = CW'(DIV_A - 1);
      2'd1:    div_lim = CW'(DIV_B - 1);
      default: div_lim = CW'(DIV_C - 1);
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_IDLE;
      go_q    <= 1'b0;
      done_n  <= 1'b1;
      armed   <= 1'b1;
      chan_q  <= '0;
      pins_q  <= '0;
      clk_sel <= '0;
      div_cnt <= '0;
      sar     <= '0;
      mask    <= '0;
      res     <= '0;
      irq     <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (ctrl_wr) begin
        go_q   <= bus_wdata[7];
        chan_q <= bus_wdata[5:3];
        pins_q <= bus_wdata[2:0];
      end
      if (bus_wr && bus_addr == 2'd1) clk_sel <= bus_wdata[6:5];
      if (chan_chg) begin
        armed  <= 1'b0;
        done_n <= 1'b0;
        st     <= S_IDLE;
        mask   <= '0;
      end else if (go_fall && !armed) begin
        armed  <= 1'b1;
        done_n <= 1'b1;
      end else if (go_fall) begin
        done_n  <= 1'b1;
        st      <= S_SAMP;
        div_cnt <= '0;
        sar     <= '0;
        mask    <= '0;
      end else if (st != S_IDLE) begin
        div_cnt <= tick ? '0 : div_cnt + 1'b1;
        if (tick) begin
          if (st == S_SAMP) begin
            st   <= S_TRIAL;
            mask <= 10'h200;
          end else begin
            if (cmp_ge) sar <= sar | mask;
            mask <= mask >> 1;
            if (mask[0]) begin
              st     <= S_IDLE;
              res    <= cmp_ge ? (sar | mask) : sar;
              done_n <= 1'b0;
              irq    <= irq_global_en && irq_adc_en;
            end
          end
        end
      end
    end

  assign chan_sel   = chan_q;
  assign pin_ana_en = pins_q;
  assign trial_code = sar | mask;
  assign sample_en  = st == S_SAMP;

  always_comb
    case (bus_addr)
      2'd0:    bus_rdata = {go_q, done_n, chan_q, pins_q};
      2'd1:    bus_rdata = {1'b0, clk_sel, 5'b0};
      2'd2:    bus_rdata = res[9:2];
      default: bus_rdata = {res[1:0], 6'b0};
    endcase

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R8
  AST_IRQ_AT_FLAG_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!done_n && $past(done_n))); // R8
  AST_SAMPLE_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> done_n); // R3
  AST_FLAG_RISE_NEEDS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_n) |-> $past(bus_wr && bus_addr == 2'd0 && !bus_wdata[7])); // R7
  AST_TRIAL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask)); // R4
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(done_n) |-> $stable(res)); // R5
endmodule

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0;
  logic       bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic       g_en = 0, a_en = 0, cmp_ge;
  logic [2:0] chan_sel, pin_ana_en;
  logic [9:0] trial_code;
  logic       sample_en, irq;
  logic [9:0] vin [8];

  int checks = 0, errors = 0;
  logic [2:0] cur_ch = 0;
  logic [9:0] last_res = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always_comb cmp_ge = vin[chan_sel] >= trial_code;

  adc_seq_ctrl u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_global_en(g_en),
    .irq_adc_en(a_en), .cmp_ge(cmp_ge), .chan_sel(chan_sel), .pin_ana_en(pin_ana_en),
    .trial_code(trial_code), .sample_en(sample_en), .irq(irq));

  function automatic int lat(input logic [1:0] sel);
    return 11 * (sel == 2'd0 ? 2 : sel == 2'd1 ? 8 : 32);
  endfunction
  function automatic logic [7:0] exp_hi(input logic [9:0] v); return v[9:2]; endfunction
  function automatic logic [7:0] exp_lo(input logic [9:0] v); return {v[1:0], 6'b0}; endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); #1;
    bus_wr = 0; bus_addr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata; bus_addr = 0; #1;
  endtask

  task automatic pulse(input logic [2:0] ch, input logic [2:0] pins);
    wr(0, {2'b10, ch, pins});
    wr(0, {2'b00, ch, pins});
  endtask

  task automatic run_conv(input logic [2:0] ch, input logic [2:0] pins, input logic [1:0] sel,
                          input string tag);
    int cnt, nirq;
    logic [7:0] d;
    logic irq_exp;
    irq_exp = g_en & a_en;
    wr(1, {1'b0, sel, 5'b0});
    pulse(ch, pins);
    chk({tag, " R3 flag after start"}, {31'b0, bus_rdata[6]}, 1);
    cnt = 0; nirq = 0;
    while (bus_rdata[6] && cnt < 2000) begin
      @(posedge clk); #1;
      cnt++;
      if (irq) nirq++;
      if (cnt == 1) chk({tag, " R3 sample step"}, {31'b0, sample_en}, 1);
      if (cnt == 3) begin
        rd(2, d); chk({tag, " R5 hi held"}, d, exp_hi(last_res));
        rd(3, d); chk({tag, " R5 lo held"}, d, exp_lo(last_res));
      end
    end
    chk({tag, " R6 latency"}, cnt, lat(sel));
    chk({tag, " R8 irq at flag fall"}, {31'b0, irq}, {31'b0, irq_exp});
    @(posedge clk); #1;
    chk({tag, " R8 irq single cycle"}, nirq + (irq ? 1 : 0), irq_exp ? 1 : 0);
    rd(2, d); chk({tag, " R4 result hi"}, d, exp_hi(vin[ch]));
    rd(3, d); chk({tag, " R4 R5 result lo"}, d, exp_lo(vin[ch]));
    last_res = vin[ch];
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL R3 watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) vin[i] = 10'(i * 97 + 5);
    vin[0] = 10'h2A5;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;

    rd(0, d); chk("R1 ctrl reset", d, 8'h40);
    rd(1, d); chk("R1 clksel reset", d, 0);
    rd(2, d); chk("R1 hi reset", d, 0);
    rd(3, d); chk("R1 lo reset", d, 0);
    chk("R1 outputs reset", {irq, sample_en, trial_code}, 0);

    wr(0, 8'b0000_0101);
    chk("R10 pins", pin_ana_en, 3'b101);
    chk("R10 chan", chan_sel, 0);
    wr(0, 8'b1000_0101);
    repeat (6) @(posedge clk); #1;
    chk("R2 no sample on rising write", {31'b0, sample_en}, 0);
    chk("R2 trial code idle", trial_code, 0);
    wr(0, 8'b0000_0101);
    @(posedge clk); #1;
    chk("R3 conversion runs after falling write", {31'b0, sample_en}, 1);
    while (bus_rdata[6]) begin @(posedge clk); #1; end
    rd(2, d); chk("R4 first result hi", d, exp_hi(vin[0]));
    last_res = vin[0];

    g_en = 1; a_en = 1;
    run_conv(0, 3'b101, 2'd1, "div8 irq");
    run_conv(0, 3'b101, 2'd3, "div32");
    g_en = 1; a_en = 0;
    run_conv(0, 3'b101, 2'd0, "irq adc off");
    g_en = 0; a_en = 1;
    run_conv(0, 3'b101, 2'd0, "irq global off");

    // R9 abort in mid conversion
    wr(1, 8'h20);
    pulse(0, 3'b101);
    repeat (40) @(posedge clk); #1;
    begin
      int cnt = 0;
      pulse(0, 3'b101);
      chk("R9 flag after restart", {31'b0, bus_rdata[6]}, 1);
      while (bus_rdata[6] && cnt < 2000) begin @(posedge clk); #1; cnt++; end
      chk("R9 restart latency", cnt, lat(2'd1));
      rd(2, d); chk("R9 result hi", d, exp_hi(vin[0]));
    end
    last_res = vin[0];

    // R7 channel change disarms
    vin[3] = 10'h3FF;
    wr(0, 8'b0001_1101);
    rd(0, d); chk("R7 flag cleared on channel change", {31'b0, d[6]}, 0);
    chk("R10 chan updated", {chan_sel, pin_ana_en}, {3'd3, 3'b101});
    wr(1, 8'h00);
    pulse(3, 3'b101);
    chk("R7 arming pulse sets flag", {31'b0, bus_rdata[6]}, 1);
    begin
      int bad = 0;
      repeat (10) begin @(posedge clk); #1; if (sample_en || bus_rdata[6] !== 1'b1) bad++; end
      chk("R7 arming pulse does not convert", bad, 0);
    end
    run_conv(3, 3'b101, 2'd0, "after arm top code");
    cur_ch = 3;
    vin[3] = 10'h000;
    run_conv(3, 3'b110, 2'd0, "R7 pins only change zero code");

    for (int it = 0; it < 20; it++) begin
      logic [2:0] ch, pins;
      logic [1:0] sel;
      ch = 3'($urandom % 8); pins = 3'($urandom % 8); sel = 2'($urandom % 4);
      vin[ch] = 10'($urandom);
      g_en = 1'($urandom); a_en = 1'($urandom);
      if (ch != cur_ch) begin
        pulse(ch, pins);
        chk("R7 random arm flag", {31'b0, bus_rdata[6]}, 1);
        @(posedge clk); #1;
        chk("R7 random arm no sample", {31'b0, sample_en}, 0);
        cur_ch = ch;
      end
      run_conv(ch, pins, sel, "random");
      chk("R10 random fields", {chan_sel, pin_ana_en}, {ch, pins});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule